// File: doc/BRIEF.md
# Audio Streaming Control and Clock Status Registers

This block is the register file that a host uses to own, configure and watch an audio streaming device that sits on a serial bus. It keeps the 64-bit address of the current owner and a word of recent events. It also holds the clock source and rate selection, a stream-run control, and the lock and slip state of eleven clock sources together with the state of the current one. A simple request port carries quadlet reads, quadlet writes, and a 64-bit compare-and-swap that is aimed at the owner. Each request gets a response one cycle later.

The clock subsystem supplies the live lock flags, the single-cycle slip pulses, the lock of the current source and its nominal rate code. When something the host must hear about happens, the block records a new event word and offers it on a valid/ready notification port, along with the owner address that the word should be delivered to. Packet framing, clock recovery and name storage belong to other blocks.

Top module: `audio_ctl_regs`

## Requirements
- R1: After rst_n, the owner reads 0xFFFF_0000_0000_0000, the event word reads 0, clock select reads 0x0000_020C (clk_source 0x0C, clk_rate 0x02), the stream-run register reads 0, stream_run is 0 and ntf_valid is 0.
- R2: A compare-and-swap (req_op 2) at quadlet 0 always returns the owner value it found on rsp_old. It replaces the owner with req_swap only when that value equals req_cmp. A compare-and-swap at any other quadlet changes nothing and returns 0.
- R3: Plain writes (req_op 1) to the owner (quadlets 0, 1), the event word (2), status (5) and extended status (6) have no effect.
- R4: A bus_reset pulse puts the owner back to 0xFFFF_0000_0000_0000 and clears the stream-run register. Clock select keeps its value.
- R5: A write to clock select (quadlet 3) stores bits 15:0: the source in bits 7:0 and the rate code in bits 15:8. Bits 31:16 read as 0. clk_source and clk_rate follow the stored value, and the write raises event bit 5.
- R6: The stream-run register (quadlet 4) stores the full 32-bit write. stream_run is 1 exactly when that value is non-zero.
- R7: The event bits are: bit 0 receive configuration change (rx_cfg_chg), bit 1 transmit configuration change (tx_cfg_chg), bit 4 current-source lock change, bit 5 clock select accepted, bit 6 extended-status lock change. Events that arise in one cycle replace the whole earlier word.
- R8: The edge that records new events also sets ntf_valid and loads ntf_event with the word and ntf_dest with the owner value of that cycle. Without ready the three hold steady. A newer event replaces the pending one. ntf_valid drops after a cycle with ntf_ready high and no new event.
- R9: In the extended status word (quadlet 6), bits 10:0 show src_locked live. Any change of src_locked raises event bit 6.
- R10: Extended status bits 26:16 are sticky slip flags, set by src_slip pulses. They raise no event and are cleared by a quadlet read of quadlet 6. A slip pulse in the same cycle as that read is kept for the next read.
- R11: The status word (quadlet 5) has cur_locked in bit 0 and nominal_rate in bits 15:8. A change of cur_locked raises event bit 4.
- R12: Every request gives rsp_valid one cycle later. A read returns, by quadlet, 0 owner[63:32], 1 owner[31:0], 2 event word, 3 clock select, 4 stream-run value, 5 status, 6 extended status, and 0 for any other quadlet. Writes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle bus reset indication |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 compare-and-swap |
| req_addr | input | ADDR_W | Quadlet index |
| req_wdata | input | 32 | Write data |
| req_cmp | input | 64 | Compare operand |
| req_swap | input | 64 | Swap operand |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| rsp_old | output | 64 | Owner value found by a compare-and-swap |
| src_locked | input | NUM_SRC | Live lock flag for each clock source |
| src_slip | input | NUM_SRC | Slip pulse for each clock source |
| cur_locked | input | 1 | Current source locked |
| nominal_rate | input | 8 | Nominal rate code |
| rx_cfg_chg | input | 1 | Receive configuration change pulse |
| tx_cfg_chg | input | 1 | Transmit configuration change pulse |
| clk_source | output | 8 | Selected clock source |
| clk_rate | output | 8 | Selected rate code |
| stream_run | output | 1 | Streaming enabled |
| ntf_valid | output | 1 | Notification pending |
| ntf_ready | input | 1 | Notification accepted |
| ntf_event | output | 32 | Event word to deliver |
| ntf_dest | output | 64 | Destination owner address |

## Verification
The hardest case to reach is a slip pulse that lands in the same cycle as the quadlet read that clears the slip flags. The bench drives that pulse and the read request together on one edge. It then expects the read to return the old flags and the next read to show the new bit. Replacing a pending notification before it is accepted is also hard to reach. The bench holds ntf_ready low while it raises a clock-select event and then a pair of configuration changes, and checks that only the newer word and the original destination remain.

// File: rtl/acr_pkg.sv
// Shared constants and types for the audio control register block.
// Assumes quadlet addressing; event bit positions are fixed by the host side.
package acr_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CAS   = 2'd2
    } req_op_e;

    localparam logic [63:0] NO_OWNER   = 64'hFFFF_0000_0000_0000;
    localparam logic [15:0] CLKSEL_RST = 16'h020C;

    localparam int A_OWN_HI = 0;
    localparam int A_OWN_LO = 1;
    localparam int A_EVENT  = 2;
    localparam int A_CLKSEL = 3;
    localparam int A_RUN    = 4;
    localparam int A_STATUS = 5;
    localparam int A_EXT    = 6;

    localparam int EV_RX     = 0;
    localparam int EV_TX     = 1;
    localparam int EV_LOCK   = 4;
    localparam int EV_CLKACC = 5;
    localparam int EV_EXT    = 6;

    localparam int SLIP_LSB = 16;
endpackage

// File: rtl/acr_owner.sv
// Owner address register. Changes only by compare-and-swap or bus reset.
// Assumes cas_en is a single-cycle strobe already decoded for the owner.
module acr_owner import acr_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_reset,
    input  logic        cas_en,
    input  logic [63:0] cmp,
    input  logic [63:0] swap,
    output logic [63:0] owner_q
);
    // Hold owner; bus reset wins over a same-cycle swap.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset)
            owner_q <= NO_OWNER;
        else if (cas_en && owner_q == cmp)
            owner_q <= swap;
    end

    assert_busrst_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> owner_q == NO_OWNER);

    assert_cas_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_en && !bus_reset) |=> $stable(owner_q));
endmodule

// File: rtl/acr_sync_status.sv
// Clock status tracker: registers lock flags to detect changes and keeps
// sticky per-source slip flags. Assumes slip inputs are already synchronous.
module acr_sync_status #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_locked,
    input  logic [NUM_SRC-1:0] src_slip,
    input  logic               cur_locked,
    input  logic               rd_clear,
    output logic [NUM_SRC-1:0] slip_q,
    output logic               ext_chg,
    output logic               cur_chg
);
    logic [NUM_SRC-1:0] lock_q;
    logic               cur_q;

    // Remember last lock state to find changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            cur_q  <= 1'b0;
        end else begin
            lock_q <= src_locked;
            cur_q  <= cur_locked;
        end
    end

    assign ext_chg = |(src_locked ^ lock_q);
    assign cur_chg = cur_locked ^ cur_q;

    // One sticky flag per source; a new pulse beats the clearing read.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slip
        always_ff @(posedge clk) begin
            if (!rst_n)
                slip_q[g] <= 1'b0;
            else
                slip_q[g] <= src_slip[g] | (slip_q[g] & ~rd_clear);
        end
    end

    assert_slip_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clear |=> ((slip_q & $past(slip_q)) == $past(slip_q)));

    assert_slip_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_slip) |=> ((slip_q & $past(src_slip)) == $past(src_slip)));
endmodule

// File: rtl/acr_notify.sv
// Event word and notification port. New events replace the word and the
// pending notification; assumes the owner input is the current owner value.
module acr_notify #(
    parameter int EV_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev,
    input  logic [63:0]     owner,
    input  logic            ready,
    output logic            valid,
    output logic [EV_W-1:0] evt_q,
    output logic [63:0]     dest_q
);
    // Capture new events, otherwise retire an accepted notification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            evt_q  <= '0;
            dest_q <= '0;
        end else if (|ev) begin
            valid  <= 1'b1;
            evt_q  <= ev;
            dest_q <= owner;
        end else if (valid && ready) begin
            valid  <= 1'b0;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && ev == '0) |=> (valid && $stable(evt_q) && $stable(dest_q)));

    assert_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> valid);
endmodule

// File: rtl/audio_ctl_regs.sv
// Control and status register file for an audio streaming device.
// Decodes quadlet read/write and owner compare-and-swap, answers one cycle
// later, and raises notifications. Assumes NUM_SRC <= 16.
module audio_ctl_regs import acr_pkg::*; #(
    parameter int NUM_SRC = 11,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_reset,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [63:0]        req_cmp,
    input  logic [63:0]        req_swap,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [63:0]        rsp_old,
    input  logic [NUM_SRC-1:0] src_locked,
    input  logic [NUM_SRC-1:0] src_slip,
    input  logic               cur_locked,
    input  logic [7:0]         nominal_rate,
    input  logic               rx_cfg_chg,
    input  logic               tx_cfg_chg,
    output logic [7:0]         clk_source,
    output logic [7:0]         clk_rate,
    output logic               stream_run,
    output logic               ntf_valid,
    input  logic               ntf_ready,
    output logic [31:0]        ntf_event,
    output logic [63:0]        ntf_dest
);
    localparam int EV_W = 32;

    logic               is_rd, is_wr, is_cas;
    logic               cas_own, wr_clksel, wr_run, ext_clear;
    logic [63:0]        owner_q;
    logic [15:0]        clksel_q;
    logic [31:0]        run_q;
    logic [NUM_SRC-1:0] slip_q;
    logic               ext_chg, cur_chg;
    logic [EV_W-1:0]    ev;
    logic [31:0]        ext_word, rd_mux;

    // Decode the request into per-register strobes.
    always_comb begin
        is_rd     = req_valid && req_op == OP_READ;
        is_wr     = req_valid && req_op == OP_WRITE;
        is_cas    = req_valid && req_op == OP_CAS;
        cas_own   = is_cas && req_addr == ADDR_W'(A_OWN_HI);
        wr_clksel = is_wr && req_addr == ADDR_W'(A_CLKSEL);
        wr_run    = is_wr && req_addr == ADDR_W'(A_RUN);
        ext_clear = is_rd && req_addr == ADDR_W'(A_EXT);
    end

    acr_owner u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_reset(bus_reset),
        .cas_en   (cas_own),
        .cmp      (req_cmp),
        .swap     (req_swap),
        .owner_q  (owner_q)
    );

    acr_sync_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_locked(src_locked),
        .src_slip  (src_slip),
        .cur_locked(cur_locked),
        .rd_clear  (ext_clear),
        .slip_q    (slip_q),
        .ext_chg   (ext_chg),
        .cur_chg   (cur_chg)
    );

    // Clock selection register; survives bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clksel_q <= CLKSEL_RST;
        else if (wr_clksel)
            clksel_q <= req_wdata[15:0];
    end

    // Stream-run register; cleared by bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset)
            run_q <= '0;
        else if (wr_run)
            run_q <= req_wdata;
    end

    assign clk_source = clksel_q[7:0];
    assign clk_rate   = clksel_q[15:8];
    assign stream_run = |run_q;

    // Gather this cycle's events into one word.
    always_comb begin
        ev            = '0;
        ev[EV_RX]     = rx_cfg_chg;
        ev[EV_TX]     = tx_cfg_chg;
        ev[EV_LOCK]   = cur_chg;
        ev[EV_CLKACC] = wr_clksel;
        ev[EV_EXT]    = ext_chg;
    end

    acr_notify #(.EV_W(EV_W)) u_notify (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .owner (owner_q),
        .ready (ntf_ready),
        .valid (ntf_valid),
        .evt_q (ntf_event),
        .dest_q(ntf_dest)
    );

    // Build the extended status word from live locks and sticky slips.
    always_comb begin
        ext_word = '0;
        ext_word[NUM_SRC-1:0] = src_locked;
        ext_word[SLIP_LSB +: NUM_SRC] = slip_q;
    end

    // Select read data by quadlet index.
    always_comb begin
        case (req_addr)
            ADDR_W'(A_OWN_HI): rd_mux = owner_q[63:32];
            ADDR_W'(A_OWN_LO): rd_mux = owner_q[31:0];
            ADDR_W'(A_EVENT):  rd_mux = ntf_event;
            ADDR_W'(A_CLKSEL): rd_mux = {16'h0, clksel_q};
            ADDR_W'(A_RUN):    rd_mux = run_q;
            ADDR_W'(A_STATUS): rd_mux = {16'h0, nominal_rate, 7'h0, cur_locked};
            ADDR_W'(A_EXT):    rd_mux = ext_word;
            default:           rd_mux = '0;
        endcase
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_old   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= is_rd ? rd_mux : 32'h0;
            rsp_old   <= cas_own ? owner_q : 64'h0;
        end
    end

    assert_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_run_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !stream_run);

    assert_clk_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clksel |=> (ntf_valid && ntf_event[EV_CLKACC]));

    assert_clksel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clksel |=> $stable(clksel_q));
endmodule

// File: tb/audio_ctl_regs_tb_top.sv
// Scoreboard bench: request tasks queue the expected response, a monitor
// compares each response as it appears; direct checks cover side outputs.
module audio_ctl_regs_tb_top;
    localparam int NS = 11;
    localparam int AW = 4;
    localparam logic [63:0] NOOWN = 64'hFFFF_0000_0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_reset = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [63:0]   req_cmp = '0;
    logic [63:0]   req_swap = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [63:0]   rsp_old;
    logic [NS-1:0] src_locked = '0;
    logic [NS-1:0] src_slip = '0;
    logic          cur_locked = 1'b0;
    logic [7:0]    nominal_rate = 8'h04;
    logic          rx_cfg_chg = 1'b0;
    logic          tx_cfg_chg = 1'b0;
    logic [7:0]    clk_source, clk_rate;
    logic          stream_run, ntf_valid;
    logic          ntf_ready = 1'b0;
    logic [31:0]   ntf_event;
    logic [63:0]   ntf_dest;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_rd[$];
    logic [63:0] exp_old[$];
    string       exp_tag[$];

    always #2 clk = ~clk;

    audio_ctl_regs #(.NUM_SRC(NS), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cmp(req_cmp), .req_swap(req_swap),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_old(rsp_old),
        .src_locked(src_locked), .src_slip(src_slip), .cur_locked(cur_locked),
        .nominal_rate(nominal_rate), .rx_cfg_chg(rx_cfg_chg), .tx_cfg_chg(tx_cfg_chg),
        .clk_source(clk_source), .clk_rate(clk_rate), .stream_run(stream_run),
        .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_event(ntf_event),
        .ntf_dest(ntf_dest)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All request tasks start and end just after a rising edge.
    task automatic issue(logic [1:0] op, int addr, logic [31:0] wd,
                         logic [63:0] cmp, logic [63:0] swp,
                         logic [31:0] erd, logic [63:0] eold, string tag);
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
        req_wdata = wd; req_cmp = cmp; req_swap = swp;
        exp_rd.push_back(erd); exp_old.push_back(eold); exp_tag.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic rd(int addr, logic [31:0] e, string tag);
        issue(2'd0, addr, 32'h0, 64'h0, 64'h0, e, 64'h0, tag);
    endtask

    task automatic wr(int addr, logic [31:0] d, string tag);
        issue(2'd1, addr, d, 64'h0, 64'h0, 32'h0, 64'h0, tag);
    endtask

    task automatic cas(int addr, logic [63:0] c, logic [63:0] s, logic [63:0] eold, string tag);
        issue(2'd2, addr, 32'h0, c, s, 32'h0, eold, tag);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic accept();
        ntf_ready = 1'b1; step(); ntf_ready = 1'b0;
    endtask

    // Monitor: pop one expected response for every response seen.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_rd.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: actual unexpected response expected none");
            end else begin
                string t;
                logic [31:0] er;
                logic [63:0] eo;
                t = exp_tag.pop_front(); er = exp_rd.pop_front(); eo = exp_old.pop_front();
                check(t, {32'h0, rsp_rdata}, {32'h0, er});
                check({t, " old"}, rsp_old, eo);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] own_a;
        own_a = 64'h0001_0000_0000_1000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 ntf_valid", {63'h0, ntf_valid}, 64'h0);
        check("R1 stream_run", {63'h0, stream_run}, 64'h0);
        check("R1 clk_source", {56'h0, clk_source}, 64'h0C);
        check("R1 clk_rate", {56'h0, clk_rate}, 64'h02);
        rd(0, 32'hFFFF_0000, "R1 owner hi");
        rd(1, 32'h0, "R1 owner lo");
        rd(2, 32'h0, "R1 event word");
        rd(3, 32'h0000_020C, "R1 clock select");
        rd(4, 32'h0, "R1 run");

        // R12 map: status and unmapped quadlet
        rd(5, 32'h0000_0400, "R12 status");
        rd(9, 32'h0, "R12 unmapped");

        // R3 writes to read-only quadlets
        wr(0, 32'h1234_5678, "R3 wr owner hi");
        wr(1, 32'h1234_5678, "R3 wr owner lo");
        wr(2, 32'h1234_5678, "R3 wr event");
        wr(5, 32'h1234_5678, "R3 wr status");
        wr(6, 32'h1234_5678, "R3 wr ext");
        check("R3 no event", {63'h0, ntf_valid}, 64'h0);
        rd(0, 32'hFFFF_0000, "R3 owner hi kept");
        rd(1, 32'h0, "R3 owner lo kept");
        rd(2, 32'h0, "R3 event kept");
        rd(6, 32'h0, "R3 ext kept");

        // R2 compare-and-swap
        cas(0, 64'h0, own_a, NOOWN, "R2 cas miss");
        rd(0, 32'hFFFF_0000, "R2 miss unchanged");
        cas(0, NOOWN, own_a, NOOWN, "R2 cas hit");
        rd(0, 32'h0001_0000, "R2 owner hi");
        rd(1, 32'h0000_1000, "R2 owner lo");
        cas(3, own_a, 64'h5, 64'h0, "R2 cas wrong quadlet");
        rd(1, 32'h0000_1000, "R2 wrong quadlet unchanged");

        // R5 clock select write and accepted event
        wr(3, 32'hABCD_0305, "R5 wr clock select");
        check("R5 event", {32'h0, ntf_event}, 64'h20);
        check("R8 valid", {63'h0, ntf_valid}, 64'h1);
        check("R8 dest", ntf_dest, own_a);
        check("R5 clk_source", {56'h0, clk_source}, 64'h05);
        check("R5 clk_rate", {56'h0, clk_rate}, 64'h03);
        rd(3, 32'h0000_0305, "R5 clock select read");

        // R7 and R8: replace pending word before acceptance
        step(); step();
        check("R8 hold", {32'h0, ntf_event}, 64'h20);
        rx_cfg_chg = 1'b1; tx_cfg_chg = 1'b1;
        step();
        rx_cfg_chg = 1'b0; tx_cfg_chg = 1'b0;
        check("R7 replaced word", {32'h0, ntf_event}, 64'h03);
        check("R8 still valid", {63'h0, ntf_valid}, 64'h1);
        accept();
        check("R8 accepted", {63'h0, ntf_valid}, 64'h0);
        rd(2, 32'h0000_0003, "R7 event word read");

        // R6 stream run
        wr(4, 32'h0000_0005, "R6 wr run");
        check("R6 run on", {63'h0, stream_run}, 64'h1);
        rd(4, 32'h0000_0005, "R6 run read");
        wr(4, 32'h0, "R6 wr stop");
        check("R6 run off", {63'h0, stream_run}, 64'h0);
        wr(4, 32'h8000_0000, "R6 wr top bit");
        check("R6 run top bit", {63'h0, stream_run}, 64'h1);

        // R4 bus reset
        bus_reset = 1'b1; step(); bus_reset = 1'b0;
        check("R4 run cleared", {63'h0, stream_run}, 64'h0);
        rd(0, 32'hFFFF_0000, "R4 owner hi");
        rd(1, 32'h0, "R4 owner lo");
        rd(3, 32'h0000_0305, "R4 clock select kept");

        // R9 live lock flags raise event bit 6
        src_locked = 11'h401;
        step();
        check("R9 event", {32'h0, ntf_event}, 64'h40);
        check("R9 dest", ntf_dest, NOOWN);
        rd(6, 32'h0000_0401, "R9 ext read");
        accept();

        // R11 current lock and rate
        cur_locked = 1'b1;
        step();
        check("R11 event", {32'h0, ntf_event}, 64'h10);
        rd(5, 32'h0000_0401, "R11 status read");
        accept();

        // R10 sticky slips, no event, clear on read, same-cycle pulse kept
        src_slip = 11'h008; step(); src_slip = '0;
        step();
        check("R10 no event", {63'h0, ntf_valid}, 64'h0);
        rd(6, 32'h0008_0401, "R10 slip seen");
        rd(6, 32'h0000_0401, "R10 slip cleared");
        src_slip = 11'h004;
        rd(6, 32'h0000_0401, "R10 read with pulse");
        src_slip = '0;
        rd(6, 32'h0004_0401, "R10 pulse kept");
        rd(6, 32'h0000_0401, "R10 cleared again");

        step(); step();
        if (exp_rd.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12: actual %0d responses missing expected 0", exp_rd.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule